// File: doc/BRIEF.md
# Serial PSRAM Write-Then-Read Sequencer

This block runs single-lane serial transactions against a serial pseudo-static RAM. It reads everything it needs from one incoming word stream. Each transaction starts with a 16-bit header. The header gives how many bits go out to the memory and how many bits come back. The data bits to send follow the header in the same stream. Chip select goes active for the first outgoing bit. The block drives every outgoing bit on MOSI, then clocks in the requested number of bits from MISO. It then releases chip select and reads the next header.

The incoming stream is treated as one continuous bit sequence, most significant bit first. Received bits are packed the same way into words of `WORD_W` bits. Those words leave through a valid/ready stream. The bit clock is derived from the system clock: each SCK half-period lasts `DIV` system clocks. The `FAST` parameter selects high-speed timing. In that mode one extra SCK cycle is inserted before the receive phase, and MISO is sampled at the falling edge rather than the rising edge.

Top module: `spi_seq`

## Requirements
- R1: A header is 16 stream bits taken most significant first. Its first 8 bits are the transmit bit count and its last 8 bits are the receive bit count. The stream bits that follow are the transmit data.
- R2: `cs_n` stays high while a header is being read. It goes low together with the first transmit bit and stays low without a break until the last receive bit (or, with no receive phase, the last transmit bit). There is exactly one low window per transaction.
- R3: Transmit bits appear on `mosi` most significant first. `mosi` changes only while `sck` is low. The transmit phase has exactly as many `sck` rising edges as the transmit count.
- R4: With a receive count of zero, the block releases `cs_n` right after the last transmit high phase. No further `sck` edges are issued.
- R5: With `FAST`=0, `miso` is sampled at each `sck` rising edge of the receive phase. There are exactly as many receive rising edges as the receive count.
- R6: With `FAST`=1 and a non-zero receive count, one extra full `sck` cycle is issued between the phases. `miso` is then sampled at each falling edge of the receive phase.
- R7: Received bits are packed most significant first into `WORD_W`-bit words. A word is offered on `rx_data` once `WORD_W` bits have been collected. A partial word carries over into the next transaction.
- R8: A header with a transmit count of zero raises `cmd_err` for one cycle. That transaction issues no `sck` edge and does not assert `cs_n`.
- R9: When a completed receive word is not accepted, `rx_valid` and `rx_data` hold. `sck` stays in its present level until `rx_ready` frees room for the next sample.
- R10: Each `sck` half-period lasts `DIV` clocks when nothing stalls. `sck` is low whenever `cs_n` is high.
- R11: After reset, `sck`=0, `cs_n`=1, `tx_ready`=1, `rx_valid`=0 and `cmd_err`=0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tx_data | input | WORD_W | Incoming word: headers and transmit bits |
| tx_valid | input | 1 | Incoming word valid |
| tx_ready | output | 1 | Block can take an incoming word |
| rx_data | output | WORD_W | Packed received word |
| rx_valid | output | 1 | Received word valid |
| rx_ready | input | 1 | Consumer takes the received word |
| sck | output | 1 | Serial clock to the memory |
| cs_n | output | 1 | Chip select, active low |
| mosi | output | 1 | Serial data to the memory |
| miso | input | 1 | Serial data from the memory, no synchronizer |
| cmd_err | output | 1 | One-cycle pulse on a zero transmit count |

## Verification
Two events can fall on the same clock edge: a receive word completing, and the divider tick that would take the next MISO sample. If the consumer has not drained the word by then, the sample must be deferred rather than lost. The bench provokes this by holding `rx_ready` low through a 16-bit receive in both timing modes. It checks that `sck` keeps its level (low in normal mode, high in fast mode) and that no edge is counted while the word waits. After `rx_ready` returns, it checks that both words carry the full expected pattern.

// File: rtl/spi_seq_pkg.sv
package spi_seq_pkg;
  localparam int CNT_W    = 8;
  localparam int HDR_BITS = 2 * CNT_W;
  localparam int HCNT_W   = $clog2(HDR_BITS + 1);

  typedef enum logic [2:0] {
    ST_HDR,
    ST_TX_LO,
    ST_TX_HI,
    ST_GAP_LO,
    ST_GAP_HI,
    ST_RX_LO,
    ST_RX_HI
  } seq_state_t;
endpackage

// File: rtl/spi_seq_div.sv
module spi_seq_div #(
  parameter int DIV = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic restart,
  output logic tick
);
  localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);

  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    tick  = (cnt_q == LAST);
    cnt_d = (restart || tick) ? '0 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assert_tick_spacing_R10: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> !tick);
endmodule

// File: rtl/spi_seq_txbits.sv
module spi_seq_txbits #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] wd,
  input  logic         wvalid,
  output logic         wready,
  output logic         bit_o,
  output logic         bit_valid,
  input  logic         pop
);
  localparam int BCW = $clog2(W + 1);
  localparam logic [BCW-1:0] FULL = BCW'(W);

  logic [W-1:0]   buf_q, buf_d;
  logic [BCW-1:0] left_q, left_d;

  always_comb begin
    wready    = (left_q == '0);
    bit_valid = !wready;
    bit_o     = buf_q[W-1];
    buf_d     = buf_q;
    left_d    = left_q;
    if (wvalid && wready) begin
      buf_d  = wd;
      left_d = FULL;
    end else if (pop && bit_valid) begin
      buf_d  = {buf_q[W-2:0], 1'b0};
      left_d = left_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      buf_q  <= '0;
      left_q <= '0;
    end else begin
      buf_q  <= buf_d;
      left_q <= left_d;
    end
  end

  assert_pop_has_bit_R1: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> bit_valid);
endmodule

// File: rtl/spi_seq_rxbits.sv
module spi_seq_rxbits #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic         bit_i,
  output logic         can_push,
  output logic [W-1:0] wd,
  output logic         wvalid,
  input  logic         wready
);
  localparam int BCW = $clog2(W + 1);
  localparam logic [BCW-1:0] FULL = BCW'(W);

  logic [W-1:0]   sh_q, sh_d;
  logic [BCW-1:0] cnt_q, cnt_d;

  always_comb begin
    wvalid   = (cnt_q == FULL);
    can_push = !wvalid;
    wd       = sh_q;
    sh_d     = sh_q;
    cnt_d    = cnt_q;
    if (wvalid && wready) begin
      cnt_d = '0;
    end else if (push && can_push) begin
      sh_d  = {sh_q[W-2:0], bit_i};
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q  <= '0;
      cnt_q <= '0;
    end else begin
      sh_q  <= sh_d;
      cnt_q <= cnt_d;
    end
  end

  assert_word_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (wvalid && !wready) |=> (wvalid && $stable(wd)));
  assert_push_room_R9: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> !wvalid);
endmodule

// File: rtl/spi_seq.sv
module spi_seq
  import spi_seq_pkg::*;
#(
  parameter int WORD_W = 8,
  parameter int DIV    = 2,
  parameter int FAST   = 0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [WORD_W-1:0] tx_data,
  input  logic              tx_valid,
  output logic              tx_ready,
  output logic [WORD_W-1:0] rx_data,
  output logic              rx_valid,
  input  logic              rx_ready,
  output logic              sck,
  output logic              cs_n,
  output logic              mosi,
  input  logic              miso,
  output logic              cmd_err
);
  localparam logic [HCNT_W-1:0] HDR_DONE = HCNT_W'(HDR_BITS);
  localparam logic [CNT_W-1:0]  ONE      = CNT_W'(1);

  seq_state_t          state_q, state_d;
  logic [HDR_BITS-1:0] hdr_q, hdr_d;
  logic [HCNT_W-1:0]   hcnt_q, hcnt_d;
  logic [CNT_W-1:0]    txc_q, txc_d, rxc_q, rxc_d;
  logic                mosi_q, mosi_d;
  logic                err_q, err_d;
  logic                sck_q, cs_n_q;
  logic                tick, restart, pop, push;
  logic                bit_in, bit_valid, can_push;

  spi_seq_div #(.DIV(DIV)) u_div (
    .clk(clk), .rst_n(rst_n), .restart(restart), .tick(tick)
  );

  spi_seq_txbits #(.W(WORD_W)) u_txb (
    .clk(clk), .rst_n(rst_n), .wd(tx_data), .wvalid(tx_valid), .wready(tx_ready),
    .bit_o(bit_in), .bit_valid(bit_valid), .pop(pop)
  );

  spi_seq_rxbits #(.W(WORD_W)) u_rxb (
    .clk(clk), .rst_n(rst_n), .push(push), .bit_i(miso), .can_push(can_push),
    .wd(rx_data), .wvalid(rx_valid), .wready(rx_ready)
  );

  always_comb begin
    state_d = state_q;
    hdr_d   = hdr_q;
    hcnt_d  = hcnt_q;
    txc_d   = txc_q;
    rxc_d   = rxc_q;
    mosi_d  = mosi_q;
    err_d   = 1'b0;
    pop     = 1'b0;
    push    = 1'b0;
    restart = 1'b0;
    case (state_q)
      ST_HDR: begin
        if (hcnt_q != HDR_DONE) begin
          if (bit_valid) begin
            pop    = 1'b1;
            hdr_d  = {hdr_q[HDR_BITS-2:0], bit_in};
            hcnt_d = hcnt_q + 1'b1;
          end
        end else if (hdr_q[HDR_BITS-1:CNT_W] == '0) begin
          err_d  = 1'b1;
          hcnt_d = '0;
        end else if (bit_valid) begin
          pop     = 1'b1;
          mosi_d  = bit_in;
          txc_d   = hdr_q[HDR_BITS-1:CNT_W];
          rxc_d   = hdr_q[CNT_W-1:0];
          hcnt_d  = '0;
          restart = 1'b1;
          state_d = ST_TX_LO;
        end
      end
      ST_TX_LO: if (tick) state_d = ST_TX_HI;
      ST_TX_HI: begin
        if (tick) begin
          if (txc_q != ONE) begin
            if (bit_valid) begin
              pop     = 1'b1;
              mosi_d  = bit_in;
              txc_d   = txc_q - ONE;
              state_d = ST_TX_LO;
            end
          end else begin
            txc_d = '0;
            if (rxc_q == '0)    state_d = ST_HDR;
            else if (FAST != 0) state_d = ST_GAP_LO;
            else                state_d = ST_RX_LO;
          end
        end
      end
      ST_GAP_LO: if (tick) state_d = ST_GAP_HI;
      ST_GAP_HI: if (tick) state_d = ST_RX_LO;
      ST_RX_LO: begin
        if (tick) begin
          if (FAST != 0) begin
            state_d = ST_RX_HI;
          end else if (can_push) begin
            push    = 1'b1;
            rxc_d   = rxc_q - ONE;
            state_d = ST_RX_HI;
          end
        end
      end
      ST_RX_HI: begin
        if (tick) begin
          if (FAST != 0) begin
            if (can_push) begin
              push    = 1'b1;
              rxc_d   = rxc_q - ONE;
              state_d = (rxc_q == ONE) ? ST_HDR : ST_RX_LO;
            end
          end else begin
            state_d = (rxc_q == '0) ? ST_HDR : ST_RX_LO;
          end
        end
      end
      default: state_d = ST_HDR;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_HDR;
      hdr_q   <= '0;
      hcnt_q  <= '0;
      txc_q   <= '0;
      rxc_q   <= '0;
      mosi_q  <= 1'b0;
      err_q   <= 1'b0;
      sck_q   <= 1'b0;
      cs_n_q  <= 1'b1;
    end else begin
      state_q <= state_d;
      hdr_q   <= hdr_d;
      hcnt_q  <= hcnt_d;
      txc_q   <= txc_d;
      rxc_q   <= rxc_d;
      mosi_q  <= mosi_d;
      err_q   <= err_d;
      sck_q   <= (state_d == ST_TX_HI) || (state_d == ST_GAP_HI) || (state_d == ST_RX_HI);
      cs_n_q  <= (state_d == ST_HDR);
    end
  end

  assign sck     = sck_q;
  assign cs_n    = cs_n_q;
  assign mosi    = mosi_q;
  assign cmd_err = err_q;

  assert_idle_low_R10: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |-> !sck);
  assert_mosi_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (sck && $past(sck)) |-> $stable(mosi));
  assert_err_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_err |-> (cs_n && !sck));
  assert_err_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_err |=> !cmd_err);
endmodule

// File: tb/sim_spi_seq.sv
module sim_spi_seq;
  localparam int CLK_PERIOD = 10;
  localparam int W   = 8;
  localparam int DIV = 2;

  typedef struct packed {
    logic        fast;
    logic [7:0]  tb;
    logic [7:0]  rb;
    logic [31:0] pay;
    logic [15:0] pat;
  } vec_t;

  localparam int NV = 6;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 8'd8,  8'd8,  32'hA500_0000, 16'h3C00},
    '{1'b0, 8'd16, 8'd0,  32'h1234_0000, 16'h0000},
    '{1'b0, 8'd8,  8'd16, 32'h0F00_0000, 16'hBEEF},
    '{1'b1, 8'd8,  8'd8,  32'hC300_0000, 16'h9600},
    '{1'b1, 8'd24, 8'd16, 32'h5AA5_5A00, 16'h1357},
    '{1'b1, 8'd16, 8'd0,  32'hF00D_0000, 16'h0000}
  };

  logic clk = 1'b0;
  logic rst_n;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic [W-1:0] txd [2];
  logic [W-1:0] rxd [2];
  logic txv [2], txr [2], rxv [2], rxr [2];
  logic sck [2], csn [2], mosi [2], miso [2], err [2];

  spi_seq #(.WORD_W(W), .DIV(DIV), .FAST(0)) u0 (
    .clk(clk), .rst_n(rst_n), .tx_data(txd[0]), .tx_valid(txv[0]), .tx_ready(txr[0]),
    .rx_data(rxd[0]), .rx_valid(rxv[0]), .rx_ready(rxr[0]), .sck(sck[0]), .cs_n(csn[0]),
    .mosi(mosi[0]), .miso(miso[0]), .cmd_err(err[0])
  );

  spi_seq #(.WORD_W(W), .DIV(DIV), .FAST(1)) u1 (
    .clk(clk), .rst_n(rst_n), .tx_data(txd[1]), .tx_valid(txv[1]), .tx_ready(txr[1]),
    .rx_data(rxd[1]), .rx_valid(rxv[1]), .rx_ready(rxr[1]), .sck(sck[1]), .cs_n(csn[1]),
    .mosi(mosi[1]), .miso(miso[1]), .cmd_err(err[1])
  );

  int nchk = 0, nerr = 0;
  bit done = 0;

  int rises [2], csf [2], idx [2], hmin [2], hmax [2], hrun [2], nw [2], errc [2], txb [2];
  logic [31:0] cap [2];
  logic [15:0] rxcap [2];
  logic [15:0] pat [2];
  logic pv_s [2], pv_c [2];
  bit clr [2];

  task automatic chk(bit ok, string req, longint act, longint exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // memory model and observer, sampled away from the active edge
  always @(negedge clk) begin
    for (int i = 0; i < 2; i++) begin
      if (clr[i]) begin
        rises[i] = 0; csf[i] = 0; idx[i] = 0; hmin[i] = 1000; hmax[i] = 0;
        hrun[i] = 0; nw[i] = 0; errc[i] = 0; cap[i] = '0; rxcap[i] = '0;
      end else begin
        if (pv_c[i] && !csn[i]) csf[i]++;
        if (!pv_s[i] && sck[i]) begin
          if (rises[i] < txb[i]) cap[i] = {cap[i][30:0], mosi[i]};
          if (i == 0 && rises[i] >= txb[i]) idx[i]++;
          rises[i]++;
        end
        if (pv_s[i] && !sck[i]) begin
          if (hrun[i] < hmin[i]) hmin[i] = hrun[i];
          if (hrun[i] > hmax[i]) hmax[i] = hrun[i];
          hrun[i] = 0;
          if (i == 1 && rises[i] >= txb[i] + 2) idx[i]++;
        end
        if (sck[i]) hrun[i]++;
        if (rxv[i] && rxr[i]) begin
          rxcap[i] = {rxcap[i][7:0], rxd[i]};
          nw[i]++;
        end
        if (err[i]) errc[i]++;
      end
      miso[i] = (idx[i] < 16) ? pat[i][15 - idx[i]] : 1'b0;
      pv_s[i] = sck[i];
      pv_c[i] = csn[i];
    end
  end

  task automatic send(int i, logic [7:0] w);
    @(negedge clk);
    txd[i] = w;
    txv[i] = 1'b1;
    while (!txr[i]) @(negedge clk);
    @(negedge clk);
    txv[i] = 1'b0;
  endtask

  task automatic start(int i, int tb, logic [15:0] p, bit hold);
    @(posedge clk); #1;
    clr[i] = 1; txb[i] = tb; pat[i] = p; rxr[i] = !hold;
    @(posedge clk); #1;
    clr[i] = 0;
  endtask

  task automatic issue(int i, int tb, int rb, logic [31:0] pay);
    send(i, 8'(tb));
    send(i, 8'(rb));
    for (int k = 0; k < tb / 8; k++) send(i, pay[31 - 8*k -: 8]);
  endtask

  task automatic wait_end(int i);
    int t = 0;
    while (!(csf[i] >= 1 && csn[i]) && t < 3000) begin
      @(negedge clk);
      t++;
    end
    repeat (6) @(negedge clk);
  endtask

  task automatic stall_case(int i, logic hi_level);
    int r0;
    logic s0;
    start(i, 8, 16'hC5A3, 1'b1);
    issue(i, 8, 16, 32'h6600_0000);
    while (!rxv[i]) @(negedge clk);
    repeat (3) @(negedge clk);
    r0 = rises[i];
    s0 = sck[i];
    repeat (20) @(negedge clk);
    chk(rises[i] == r0, "R9 edges during hold", rises[i], r0);
    chk(sck[i] == s0 && s0 == hi_level, "R9 sck level during hold", sck[i], hi_level);
    chk(rxv[i] && rxd[i] == 8'hC5, "R9 held word", rxd[i], 8'hC5);
    @(posedge clk); #1;
    rxr[i] = 1'b1;
    wait_end(i);
    chk(rxcap[i] == 16'hC5A3, "R9 R7 data after release", rxcap[i], 16'hC5A3);
    chk(rises[i] == 24 + i, "R9 total edges", rises[i], 24 + i);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    nchk++;
    nerr++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

  initial begin
    for (int i = 0; i < 2; i++) begin
      txd[i] = '0; txv[i] = 0; rxr[i] = 1; miso[i] = 0; clr[i] = 1;
      txb[i] = 0; pat[i] = '0; pv_s[i] = 0; pv_c[i] = 1;
    end
    rst_n = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    for (int i = 0; i < 2; i++) begin
      chk(sck[i] == 0, "R11 sck", sck[i], 0);
      chk(csn[i] == 1, "R11 cs_n", csn[i], 1);
      chk(txr[i] == 1, "R11 tx_ready", txr[i], 1);
      chk(rxv[i] == 0 && err[i] == 0, "R11 rx_valid/cmd_err", {rxv[i], err[i]}, 0);
    end

    // table walk
    for (int v = 0; v < NV; v++) begin
      int i, tb, rb, er;
      i  = VECS[v].fast ? 1 : 0;
      tb = VECS[v].tb;
      rb = VECS[v].rb;
      er = tb + rb + ((VECS[v].fast && rb != 0) ? 1 : 0);
      start(i, tb, VECS[v].pat, 1'b0);
      issue(i, tb, rb, VECS[v].pay);
      wait_end(i);
      chk(cap[i] == (VECS[v].pay >> (32 - tb)), "R1 R3 mosi bits", cap[i], VECS[v].pay >> (32 - tb));
      chk(rises[i] == er, rb == 0 ? "R4 edge count" : (i == 1 ? "R6 edge count" : "R5 edge count"),
          rises[i], er);
      chk(32'(rxcap[i]) == (32'(VECS[v].pat) >> (16 - rb)), i == 1 ? "R6 R7 rx data" : "R5 R7 rx data",
          rxcap[i], 32'(VECS[v].pat) >> (16 - rb));
      chk(csf[i] == 1 && csn[i], "R2 one select window", csf[i], 1);
      chk(hmin[i] == DIV && hmax[i] == DIV, "R10 high phase length", hmax[i], DIV);
    end

    // zero transmit count
    start(0, 0, 16'h0, 1'b0);
    send(0, 8'd0);
    send(0, 8'd8);
    repeat (40) @(negedge clk);
    chk(errc[0] == 1, "R8 error pulse count", errc[0], 1);
    chk(rises[0] == 0, "R8 no sck", rises[0], 0);
    chk(csf[0] == 0 && csn[0], "R8 cs_n stays high", csf[0], 0);

    // back-pressure coinciding with a sample edge, both modes
    stall_case(0, 1'b0);
    stall_case(1, 1'b1);

    // partial receive word carries over
    start(0, 8, 16'hA000, 1'b0);
    issue(0, 8, 4, 32'h7700_0000);
    wait_end(0);
    chk(nw[0] == 0 && !rxv[0], "R7 no word after 4 bits", nw[0], 0);
    start(0, 8, 16'h5000, 1'b0);
    issue(0, 8, 4, 32'h8800_0000);
    wait_end(0);
    chk(nw[0] == 1, "R7 one word after 8 bits", nw[0], 1);
    chk(rxcap[0] == 16'h00A5, "R7 carried word", rxcap[0], 16'h00A5);

    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule